// File: doc/BRIEF.md
# Partial Reconfiguration Engine Control Registers

This block is the host-facing register file of a partial-reconfiguration engine. Software reaches it over a simple 64-bit register bus with a write strobe, an address and a combinational read path. Through it, software resets the engine with a request/acknowledge handshake, picks a target region, and opens a load session with a start bit. It then pushes 32-bit configuration words into an internal queue and closes the session with a complete bit.

Software paces itself by polling the free-queue credit in the status register instead of relying on a blocking write port. Queued words go out as a ready/valid stream to a configuration sink. The sink reports only pass/fail style error pulses, and these are latched in a write-one-to-clear error register. When a session has been marked complete and the queue has drained, the hardware clears the start bit itself to hand the resource back.

Top module: `rcfg_csr`

## Requirements
- R1: The header register (0x00) and the two interface ID registers (0xA8 low, 0xB0 high) return the parameter values HDR_VAL, ID_LO and ID_HI. Unmapped addresses and the data register read zero.
- R2: Control bit 0 is the engine reset request and reads back as written. Control bit 4 is its acknowledge: it goes high one clock after the request is registered and low one clock after the request is cleared.
- R3: Status bits 8:0 give the credit, which is DEPTH minus the queue occupancy. Each accepted data write lowers it by one and each word taken by the sink raises it by one.
- R4: A data write (0x18) queues bits 31:0 of the write data and ignores bits 63:32. Queued words leave on word_o in write order, and each stays on word_o while word_valid_o is high and word_ready_i is low.
- R5: A data write while start (control bit 12) is clear is dropped and sets error bit 3 (protocol).
- R6: A data write while the credit is zero is dropped and sets error bit 4 (overflow). The queue contents are not changed.
- R7: A one-cycle pulse on sink_op_err_i, sink_crc_err_i or sink_incompat_i sets error bit 0, 1 or 2. Writing to the error register (0x20) clears exactly the bits written as 1. If a set and a clear of the same bit fall in one cycle, the set wins.
- R8: Status bit 16 reads 1 while start is set or while any error bit is latched, and 0 otherwise.
- R9: Writing control bit 13 (complete) while start is set records completion. Once the queue is empty, start and complete both clear on the next clock.
- R10: Control bits 9:7 hold the region select, which is readable and drives region_o.
- R11: While the reset request is registered, the queue is flushed (credit returns to DEPTH, word_valid_o low) and start and complete are cleared.
- R12: Status bits 22:20 report the phase: 3 while reset is requested, otherwise 2 while complete is pending, 1 while start is set, and 0 when idle. Status bits 27:24 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational from reg_addr_i |
| word_o | output | 32 | Configuration word toward the sink |
| word_valid_o | output | 1 | word_o holds a queued word |
| word_ready_i | input | 1 | Sink accepts word_o this cycle |
| region_o | output | 3 | Selected target region |
| sink_op_err_i | input | 1 | Sink operation error pulse |
| sink_crc_err_i | input | 1 | Sink CRC error pulse |
| sink_incompat_i | input | 1 | Sink incompatible-image pulse |

## Verification
Every register write takes effect at the clock edge that samples it. The bench drives on the falling edge and reads the combinational read port at the next falling edge, so a write's direct effects (credit, error bits, control fields, the new word on word_o) are checked one edge after the strobe. Second-order effects are due one edge later: the reset acknowledge, the queue flush under a held reset, and the hardware release of start after complete. For these the bench first reads the intermediate value and then advances one clock before checking again. Drained words are compared one per falling edge with word_ready_i held high.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam logic [7:0] OFF_HDR   = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_STS   = 8'h10;
  localparam logic [7:0] OFF_DATA  = 8'h18;
  localparam logic [7:0] OFF_ERR   = 8'h20;
  localparam logic [7:0] OFF_ID_LO = 8'hA8;
  localparam logic [7:0] OFF_ID_HI = 8'hB0;

  localparam int ERR_W     = 5;
  localparam int E_OP      = 0;
  localparam int E_CRC     = 1;
  localparam int E_INCOMP  = 2;
  localparam int E_PROTO   = 3;
  localparam int E_OVF     = 4;

  localparam int CREDIT_W  = 9;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOAD  = 3'd1,
    PH_DRAIN = 3'd2,
    PH_RESET = 3'd3
  } phase_e;
endpackage

// File: rtl/rcfg_fifo.sv
module rcfg_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rcfg_ctl.sv
module rcfg_ctl
  import rcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_data_i,
  input  logic              wr_err_i,
  input  logic [63:0]       wdata_i,
  input  logic              credit_zero_i,
  input  logic              q_empty_i,
  input  logic              sink_op_err_i,
  input  logic              sink_crc_err_i,
  input  logic              sink_incompat_i,
  output logic              rst_req_o,
  output logic              ack_o,
  output logic [2:0]        region_o,
  output logic              start_o,
  output logic              cmpl_o,
  output logic [ERR_W-1:0]  err_o,
  output logic              push_o
);
  logic             rst_req_q, ack_q, start_q, cmpl_q;
  logic [2:0]       region_q;
  logic [ERR_W-1:0] err_q, err_set, err_clr;
  logic             done;

  assign done   = start_q && cmpl_q && q_empty_i;
  assign push_o = wr_data_i && start_q && !credit_zero_i && !rst_req_q;

  always_comb begin
    err_set           = '0;
    err_set[E_OP]     = sink_op_err_i;
    err_set[E_CRC]    = sink_crc_err_i;
    err_set[E_INCOMP] = sink_incompat_i;
    err_set[E_PROTO]  = wr_data_i && !start_q;
    err_set[E_OVF]    = wr_data_i && start_q && credit_zero_i && !rst_req_q;
    err_clr           = wr_err_i ? wdata_i[ERR_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      ack_q     <= 1'b0;
      region_q  <= '0;
      start_q   <= 1'b0;
      cmpl_q    <= 1'b0;
      err_q     <= '0;
    end else begin
      ack_q <= rst_req_q;
      err_q <= (err_q & ~err_clr) | err_set;
      if (wr_ctrl_i) begin
        rst_req_q <= wdata_i[0];
        region_q  <= wdata_i[9:7];
        if (wdata_i[12])            start_q <= 1'b1;
        if (wdata_i[13] && start_q) cmpl_q  <= 1'b1;
      end
      // hardware release and reset override software sets
      if (rst_req_q || done) begin
        start_q <= 1'b0;
        cmpl_q  <= 1'b0;
      end
    end
  end

  assign rst_req_o = rst_req_q;
  assign ack_o     = ack_q;
  assign region_o  = region_q;
  assign start_o   = start_q;
  assign cmpl_o    = cmpl_q;
  assign err_o     = err_q;
endmodule

// File: rtl/rcfg_csr.sv
module rcfg_csr
  import rcfg_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter logic [63:0] HDR_VAL = 64'h3000_0000_1000_0005,
  parameter logic [63:0] ID_LO   = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_HI   = 64'hFEDC_BA98_7654_3210
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [63:0] reg_wdata_i,
  output logic [63:0] reg_rdata_o,
  output logic [31:0] word_o,
  output logic        word_valid_o,
  input  logic        word_ready_i,
  output logic [2:0]  region_o,
  input  logic        sink_op_err_i,
  input  logic        sink_crc_err_i,
  input  logic        sink_incompat_i
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CREDIT_W-1:0] DEPTH_C = CREDIT_W'(DEPTH);

  logic                wr_ctrl, wr_data, wr_err;
  logic                rst_req_q, ack_q, start_q, cmpl_q, push;
  logic [2:0]          region_q;
  logic [ERR_W-1:0]    err_q;
  logic [CW-1:0]       q_count;
  logic                q_empty, q_full;
  logic [CREDIT_W-1:0] credit;
  logic                busy;
  phase_e              phase;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == OFF_CTRL);
  assign wr_data = reg_wr_i && (reg_addr_i == OFF_DATA);
  assign wr_err  = reg_wr_i && (reg_addr_i == OFF_ERR);

  rcfg_ctl u_ctl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_ctrl_i       (wr_ctrl),
    .wr_data_i       (wr_data),
    .wr_err_i        (wr_err),
    .wdata_i         (reg_wdata_i),
    .credit_zero_i   (credit == '0),
    .q_empty_i       (q_empty),
    .sink_op_err_i   (sink_op_err_i),
    .sink_crc_err_i  (sink_crc_err_i),
    .sink_incompat_i (sink_incompat_i),
    .rst_req_o       (rst_req_q),
    .ack_o           (ack_q),
    .region_o        (region_q),
    .start_o         (start_q),
    .cmpl_o          (cmpl_q),
    .err_o           (err_q),
    .push_o          (push)
  );

  rcfg_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_req_q),
    .push_i  (push),
    .wdata_i (reg_wdata_i[31:0]),
    .pop_i   (word_ready_i),
    .rdata_o (word_o),
    .count_o (q_count),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  assign word_valid_o = !q_empty;
  assign region_o     = region_q;
  assign credit       = DEPTH_C - CREDIT_W'(q_count);
  assign busy         = start_q || (|err_q);

  always_comb begin
    if (rst_req_q)    phase = PH_RESET;
    else if (cmpl_q)  phase = PH_DRAIN;
    else if (start_q) phase = PH_LOAD;
    else              phase = PH_IDLE;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_HDR:   reg_rdata_o = HDR_VAL;
      OFF_CTRL:  reg_rdata_o = {50'b0, cmpl_q, start_q, 2'b0, region_q, 2'b0, ack_q, 3'b0, rst_req_q};
      OFF_STS:   reg_rdata_o = {36'b0, 4'b0, 1'b0, phase, 3'b0, busy, 7'b0, credit};
      OFF_ERR:   reg_rdata_o = {{(64-ERR_W){1'b0}}, err_q};
      OFF_ID_LO: reg_rdata_o = ID_LO;
      OFF_ID_HI: reg_rdata_o = ID_HI;
      default:   reg_rdata_o = '0;
    endcase
  end

  logic unused_full;
  assign unused_full = q_full;
endmodule

// File: rtl/rcfg_csr_chk.sv
module rcfg_csr_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_req,
  input logic       ack,
  input logic       start,
  input logic       cmpl,
  input logic [4:0] err,
  input logic [8:0] credit,
  input logic       data_wr,
  input logic       busy,
  input logic       word_valid_o,
  input logic       word_ready_i
);
  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) rst_req |=> ack); // R2
  AST_ACK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni) !rst_req |=> !ack); // R2
  AST_CREDIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) credit <= 9'(DEPTH)); // R3
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i && !rst_req |=> word_valid_o); // R4
  AST_PROTO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) data_wr && !start |=> err[3]); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && start && !rst_req && credit == 9'd0 |=> err[4]); // R6
  AST_BUSY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni) (|err) |-> busy); // R8
  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start) |-> $past(cmpl) || $past(rst_req)); // R9
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni) rst_req |=> !word_valid_o && !start); // R11
endmodule

bind rcfg_csr rcfg_csr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_req      (rst_req_q),
  .ack          (ack_q),
  .start        (start_q),
  .cmpl         (cmpl_q),
  .err          (err_q),
  .credit       (credit),
  .data_wr      (wr_data),
  .busy         (busy),
  .word_valid_o (word_valid_o),
  .word_ready_i (word_ready_i)
);

// File: tb/rcfg_csr_tb.sv
module rcfg_csr_tb;
  localparam int DEPTH = 16;
  localparam logic [63:0] HDR = 64'h3000_0000_1000_0005;
  localparam logic [63:0] IDL = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] IDH = 64'hFEDC_BA98_7654_3210;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] word;
  logic        wvalid;
  logic        ready = 1'b0;
  logic [2:0]  region;
  logic        s_op = 1'b0, s_crc = 1'b0, s_inc = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rcfg_csr #(.DEPTH(DEPTH), .HDR_VAL(HDR), .ID_LO(IDL), .ID_HI(IDH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .word_o(word),
    .word_valid_o(wvalid), .word_ready_i(ready), .region_o(region),
    .sink_op_err_i(s_op), .sink_crc_err_i(s_crc), .sink_incompat_i(s_inc)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [63:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [63:0] sts(input int cr, input bit bsy, input int ph);
    return (64'(ph) << 20) | (64'(bsy) << 16) | 64'(cr);
  endfunction

  task automatic t_reset_state();
    logic [63:0] d;
    reg_rd(8'h00, d); chk("R1 hdr", d, HDR);
    reg_rd(8'hA8, d); chk("R1 id_lo", d, IDL);
    reg_rd(8'hB0, d); chk("R1 id_hi", d, IDH);
    reg_rd(8'h18, d); chk("R1 data reads 0", d, 64'h0);
    reg_rd(8'h10, d); chk("R3 R12 reset status", d, sts(DEPTH, 0, 0));
    reg_rd(8'h08, d); chk("R2 reset ctrl", d, 64'h0);
    chk("R4 no word", 64'(wvalid), 64'h0);
  endtask

  task automatic t_proto();
    logic [63:0] d;
    reg_wr(8'h18, 64'h1234);
    reg_rd(8'h20, d); chk("R5 proto err", d, 64'h8);
    reg_rd(8'h10, d); chk("R5 R8 credit kept, busy", d, sts(DEPTH, 1, 0));
    reg_wr(8'h20, 64'h8);
    reg_rd(8'h20, d); chk("R7 w1c proto", d, 64'h0);
    reg_rd(8'h10, d); chk("R8 idle not busy", d, sts(DEPTH, 0, 0));
  endtask

  task automatic t_load_drain();
    logic [63:0] d;
    ready = 1'b0;
    reg_wr(8'h08, 64'h1280);
    reg_rd(8'h08, d); chk("R10 ctrl region", d, 64'h1280);
    chk("R10 region_o", 64'(region), 64'd5);
    reg_rd(8'h10, d); chk("R12 R8 loading", d, sts(DEPTH, 1, 1));
    for (int i = 0; i < DEPTH; i++) begin
      reg_wr(8'h18, {32'hDEAD_BEEF, 32'hA500_0000 + 32'(i)});
      if (i == 0) begin
        reg_rd(8'h10, d); chk("R3 credit after one", d & 64'h1FF, 64'(DEPTH - 1));
        chk("R4 first word out", {32'h0, word}, 64'hA500_0000);
      end
    end
    reg_rd(8'h10, d); chk("R3 credit zero", d & 64'h1FF, 64'h0);
    reg_wr(8'h18, 64'h5555_5555);
    reg_rd(8'h20, d); chk("R6 overflow err", d, 64'h10);
    reg_rd(8'h10, d); chk("R6 credit still zero", d & 64'h1FF, 64'h0);
    reg_wr(8'h20, 64'h10);
    reg_rd(8'h20, d); chk("R7 w1c ovf", d, 64'h0);
    @(negedge clk);
    ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R4 order valid", 64'(wvalid), 64'h1);
      chk("R4 order word", {32'h0, word}, 64'hA500_0000 + 64'(i));
      @(negedge clk);
    end
    #1 chk("R4 drained", 64'(wvalid), 64'h0);
    reg_rd(8'h10, d); chk("R3 credit full again", d & 64'h1FF, 64'(DEPTH));
    reg_wr(8'h08, 64'h3280);
    reg_rd(8'h08, d); chk("R9 complete latched", d, 64'h3280);
    reg_rd(8'h10, d); chk("R12 draining phase", d, sts(DEPTH, 1, 2));
    tick();
    reg_rd(8'h08, d); chk("R9 start released", d, 64'h0280);
    reg_rd(8'h10, d); chk("R8 idle after done", d, sts(DEPTH, 0, 0));
  endtask

  task automatic t_sink_err();
    logic [63:0] d;
    @(negedge clk); s_crc = 1'b1;
    @(negedge clk); s_crc = 1'b0;
    reg_rd(8'h20, d); chk("R7 crc latched", d, 64'h2);
    reg_rd(8'h10, d); chk("R8 busy on error", d & 64'h1_0000, 64'h1_0000);
    @(negedge clk); s_op = 1'b1; s_inc = 1'b1;
    @(negedge clk); s_op = 1'b0; s_inc = 1'b0;
    reg_rd(8'h20, d); chk("R7 op incompat latched", d, 64'h7);
    reg_wr(8'h20, 64'h1);
    reg_rd(8'h20, d); chk("R7 partial clear", d, 64'h6);
    reg_wr(8'h20, 64'h6);
    reg_rd(8'h20, d); chk("R7 full clear", d, 64'h0);
  endtask

  task automatic t_flush();
    logic [63:0] d;
    ready = 1'b0;
    reg_wr(8'h08, 64'h1000);
    for (int i = 0; i < 3; i++) reg_wr(8'h18, 64'h77 + 64'(i));
    reg_rd(8'h10, d); chk("R3 three queued", d & 64'h1FF, 64'(DEPTH - 3));
    reg_wr(8'h08, 64'h1);
    reg_rd(8'h08, d); chk("R2 req before ack", d, 64'h1001);
    tick();
    reg_rd(8'h08, d); chk("R2 R11 ack, start cleared", d, 64'h11);
    reg_rd(8'h10, d); chk("R11 R12 flushed, reset phase", d, sts(DEPTH, 0, 3));
    chk("R11 no word", 64'(wvalid), 64'h0);
    reg_wr(8'h08, 64'h0);
    reg_rd(8'h08, d); chk("R2 ack still high", d, 64'h10);
    tick();
    reg_rd(8'h08, d); chk("R2 ack dropped", d, 64'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_proto();
    t_load_drain();
    t_sink_err();
    t_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule